// File: doc/BRIEF.md
# Interleaved Tree Serializer (20 to 1)

This block turns a parallel data word into a single serial bit stream that runs at twenty times the word rate. A word offered with a strobe is held in a capture latch. Once per word period the latch is copied into four short lane shift registers, and each lane receives every fourth bit of the word. A two-level tree of 2:1 selectors merges the lanes. Two first-level selectors each build a half-rate stream, one from the odd-numbered bits and one from the even-numbered bits. A last selector interleaves those two streams into the full-rate output.

The whole block runs on one serial-rate clock. A phase counter produces the word-rate load, the quarter-rate lane shift and the selector controls as clock enables, so no derived clocks are needed. Bits are numbered 1 to 20, and bit n is `word_i[n-1]`. A word is sent bit 1 first. Consecutive words follow each other with no idle bits in between. The word in flight is never disturbed by a new strobe.

Top module: `tree_serializer`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, and for the first 20 rising edges after `rst` falls, `serial_o` is 0.
- R2: The lane registers are loaded from the latch on every 20th rising edge after reset release (edges 20, 40, 60 and so on). For the load at edge L, bit n of the latched word (`word_i[n-1]`) is on `serial_o` from edge L+n to edge L+n+1, for n = 1 to 20. Bit 1 is therefore sent first and bit 20 last.
- R3: Words loaded at consecutive loads leave back to back. Bit 1 of a word directly follows bit 20 of the word before it, with no gap cycle.
- R4: `word_i` is captured on any rising edge where `word_vld_i` is 1. If several strobes fall inside one word period, the load takes the value from the last strobe that came before the load edge.
- R5: A strobe on the load edge itself does not reach the word being loaded on that edge. It is sent with the next load instead.
- R6: If no strobe occurs during a word period, the next load repeats the word that is still held in the latch.
- R7: A strobe that arrives while a word is being sent does not change any bit of that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-rate clock; every register in the block uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | WORD_W (20) | Parallel word; bit n of the stream is `word_i[n-1]` |
| word_vld_i | input | 1 | Strobe: capture `word_i` into the latch on this edge |
| serial_o | output | 1 | Registered serial output stream |

## Verification
A word strobed at edge S goes out with the first load edge L that satisfies L > S. Its bit n is due one register stage after L+n-1, so it is sampled on the falling edge that follows edge L+n. The bench counts rising edges from reset release, so it knows that sample 21 + 20k + (n-1) holds bit n of the k-th loaded word. It rebuilds each word at exactly those samples and compares it with the value its directed scenarios predict for that load. In parallel, a behavioural model advances on every rising edge, and the output is compared with that model on every falling edge. The first 20 samples are checked to be low.

// File: rtl/tree_ser_pkg.sv
package tree_ser_pkg;

   // number of lanes is fixed by the two-level 2:1 tree
   localparam int unsigned NUM_LANES = 4;

   // word bit index (0-based) of the first element of each lane:
   // lane0 -> bits 1,5,..  lane1 -> bits 3,7,..  lane2 -> bits 2,6,..  lane3 -> bits 4,8,..
   function automatic int unsigned lane_offset(input int unsigned lane);
      case (lane)
         0:       lane_offset = 0;
         1:       lane_offset = 2;
         2:       lane_offset = 1;
         default: lane_offset = 3;
      endcase
   endfunction

endpackage

// File: rtl/ser_phase.sv
module ser_phase #(
   parameter int unsigned WORD_W = 20,
   localparam int unsigned PH_W  = $clog2(WORD_W)
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PH_W-1:0] phase_o,
   output logic            load_o,
   output logic            shift_o
);

   localparam logic [PH_W-1:0] LAST = PH_W'(WORD_W - 1);

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (rst)               ph_q <= '0;
      else if (ph_q == LAST) ph_q <= '0;
      else                   ph_q <= ph_q + 1'b1;
   end

   assign phase_o = ph_q;
   assign load_o  = (ph_q == LAST);
   // lanes advance after their fourth bit has been taken, except at the load
   assign shift_o = (ph_q[1:0] == 2'b11) && !load_o;

   // R2: the load repeats every WORD_W edges
   a_r2_phase_wrap : assert property (@(posedge clk) disable iff (rst)
      (ph_q == LAST) |=> (ph_q == '0));
   a_r2_phase_step : assert property (@(posedge clk) disable iff (rst)
      (ph_q != LAST) |=> (ph_q == PH_W'($past(ph_q) + 1'b1)));

endmodule

// File: rtl/ser_word_latch.sv
module ser_word_latch #(
   parameter int unsigned WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] d_i,
   input  logic              vld_i,
   output logic [WORD_W-1:0] q_o
);

   logic [WORD_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)        hold_q <= '0;
      else if (vld_i) hold_q <= d_i;
   end

   assign q_o = hold_q;

   // R4: a strobe captures the offered word
   a_r4_capture : assert property (@(posedge clk) disable iff (rst)
      vld_i |=> (q_o == $past(d_i)));
   // R6: without a strobe the held word stays
   a_r6_keep : assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> $stable(q_o));

endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
   parameter int unsigned DEPTH = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             shift_i,
   input  logic [DEPTH-1:0] din_i,
   output logic             head_o
);

   logic [DEPTH-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (rst)          sr_q <= '0;
      else if (load_i)  sr_q <= din_i;
      else if (shift_i) sr_q <= {1'b0, sr_q[DEPTH-1:1]};
   end

   assign head_o = sr_q[0];

   // R2: a load takes the interleaved slice of the latch
   a_r2_lane_load : assert property (@(posedge clk) disable iff (rst)
      load_i |=> (sr_q == $past(din_i)));
   // R2: a shift moves the next element to the head
   a_r2_lane_shift : assert property (@(posedge clk) disable iff (rst)
      (shift_i && !load_i) |=> (sr_q[DEPTH-2:0] == $past(sr_q[DEPTH-1:1])));
   // R7: between loads and shifts the lane holds, whatever the strobe does
   a_r7_lane_hold : assert property (@(posedge clk) disable iff (rst)
      (!load_i && !shift_i) |=> $stable(sr_q));

endmodule

// File: rtl/ser_mux_tree.sv
module ser_mux_tree #(
   parameter int unsigned LANES = 4
) (
   input  logic [LANES-1:0] head_i,
   input  logic             pair_sel_i,
   input  logic             final_sel_i,
   output logic             odd_o,
   output logic             even_o,
   output logic             bit_o
);

   // first level, half rate: odd-numbered and even-numbered bit streams
   assign odd_o  = pair_sel_i ? head_i[1] : head_i[0];
   assign even_o = pair_sel_i ? head_i[3] : head_i[2];

   // second level, full rate
   assign bit_o  = final_sel_i ? even_o : odd_o;

endmodule

// File: rtl/tree_serializer.sv
module tree_serializer #(
   parameter int unsigned WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] word_i,
   input  logic              word_vld_i,
   output logic              serial_o
);

   import tree_ser_pkg::*;

   localparam int unsigned LANE_D = WORD_W / NUM_LANES;
   localparam int unsigned PH_W   = $clog2(WORD_W);

   // elaboration-time parameter checks
   if (WORD_W % NUM_LANES != 0) begin : g_bad_width
      $error("WORD_W must be a multiple of the lane count");
   end
   if (WORD_W < 2 * NUM_LANES) begin : g_bad_depth
      $error("WORD_W must give lanes at least two deep");
   end

   logic [PH_W-1:0]      phase;
   logic                 load_en;
   logic                 shift_en;
   logic [WORD_W-1:0]    latch_q;
   logic [NUM_LANES-1:0] lane_head;
   logic                 odd_bit;
   logic                 even_bit;
   logic                 tree_bit;
   logic                 primed_q;
   logic                 ser_q;

   ser_phase #(.WORD_W(WORD_W)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .phase_o (phase),
      .load_o  (load_en),
      .shift_o (shift_en)
   );

   ser_word_latch #(.WORD_W(WORD_W)) u_latch (
      .clk   (clk),
      .rst   (rst),
      .d_i   (word_i),
      .vld_i (word_vld_i),
      .q_o   (latch_q)
   );

   for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
      logic [LANE_D-1:0] slice;
      for (genvar gk = 0; gk < LANE_D; gk++) begin : g_bit
         assign slice[gk] = latch_q[NUM_LANES * gk + lane_offset(gl)];
      end
      ser_lane #(.DEPTH(LANE_D)) u_lane (
         .clk     (clk),
         .rst     (rst),
         .load_i  (load_en),
         .shift_i (shift_en),
         .din_i   (slice),
         .head_o  (lane_head[gl])
      );
   end

   ser_mux_tree #(.LANES(NUM_LANES)) u_tree (
      .head_i      (lane_head),
      .pair_sel_i  (phase[1]),
      .final_sel_i (phase[0]),
      .odd_o       (odd_bit),
      .even_o      (even_bit),
      .bit_o       (tree_bit)
   );

   always_ff @(posedge clk) begin
      if (rst)          primed_q <= 1'b0;
      else if (load_en) primed_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) ser_q <= 1'b0;
      else     ser_q <= primed_q & tree_bit;
   end

   assign serial_o = ser_q;

   // R1: nothing leaves before the first load has filled the lanes
   a_r1_quiet_until_load : assert property (@(posedge clk) disable iff (rst)
      !primed_q |=> !serial_o);
   // R3: once loaded, the output follows the tree one edge later without gaps
   a_r3_follow_tree : assert property (@(posedge clk) disable iff (rst)
      primed_q |=> (serial_o == $past(tree_bit)));

endmodule

// File: tb/tree_serializer_bench.sv
module tree_serializer_bench;

   localparam int unsigned W = 20;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] word_i;
   logic         word_vld_i;
   logic         serial_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;

   always #4 clk = ~clk;   // 125 MHz

   tree_serializer #(.WORD_W(W)) u_tree_serializer (
      .clk        (clk),
      .rst        (rst),
      .word_i     (word_i),
      .word_vld_i (word_vld_i),
      .serial_o   (serial_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // behavioural model: phase count, held word, word in flight
   int           mph;
   logic [W-1:0] mlat, mcur;
   bit           mprim;
   logic         mout;

   always @(posedge clk) begin
      if (rst) begin
         mph = 0; mlat = '0; mcur = '0; mprim = 0; mout = 1'b0;
      end else begin
         mout = mprim ? mcur[mph] : 1'b0;
         if (mph == W - 1) begin mcur = mlat; mprim = 1; end
         if (word_vld_i) mlat = word_i;
         mph = (mph == W - 1) ? 0 : mph + 1;
      end
   end

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   // expected words per load, with the requirement each one exercises
   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   logic [W-1:0] rx;

   always @(negedge clk) begin
      if (!rst && !done && cyc >= 1) begin
         chk(serial_o === mout, "R3 per-cycle model", 32'(serial_o), 32'(mout));
         if (cyc <= W) chk(serial_o === 1'b0, "R1 low before first load", 32'(serial_o), 0);
         if (cyc >= W + 1) begin
            int idx;
            idx = (cyc - (W + 1)) % W;
            rx[idx] = serial_o;
            if (idx == W - 1 && exp_q.size() > 0) begin
               logic [W-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(rx === e, t, 32'(rx), 32'(e));
            end
         end
      end
   end

   // one word period; a strobe position of 0 means none
   task automatic period(input logic [W-1:0] w1, input int at1, input logic [W-1:0] w2, input int at2);
      for (int e = 1; e <= W; e++) begin
         word_vld_i = 1'b0;
         if (e == at1) begin word_vld_i = 1'b1; word_i = w1; end
         if (e == at2) begin word_vld_i = 1'b1; word_i = w2; end
         @(negedge clk);
      end
      word_vld_i = 1'b0;
   endtask

   task automatic expect_word(input logic [W-1:0] w, input string t);
      exp_q.push_back(w);
      tag_q.push_back(t);
   endtask

   initial begin
      rst = 1'b1; word_vld_i = 1'b0; word_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(serial_o === 1'b0, "R1 reset state", 32'(serial_o), 0);
      rst = 1'b0;

      // R2: ordering with distinctive patterns
      period(20'h00001, 5, '0, 0);  expect_word(20'h00001, "R2 bit 1 first");
      period(20'h80000, 9, '0, 0);  expect_word(20'h80000, "R2 bit 20 last");
      period(20'h55555, 12, '0, 0); expect_word(20'h55555, "R2 alternating");
      period(20'hFFFFF, 2, '0, 0);  expect_word(20'hFFFFF, "R2 all ones");
      period(20'h00000, 17, '0, 0); expect_word(20'h00000, "R3 ones then zeros");
      period(20'hC3A5F, 8, '0, 0);  expect_word(20'hC3A5F, "R2 mixed");
      // R4: last strobe of the period wins
      period(20'h12345, 3, 20'hABCDE, 15); expect_word(20'hABCDE, "R4 last strobe wins");
      // R6: no strobe repeats the held word
      period('0, 0, '0, 0);         expect_word(20'hABCDE, "R6 repeat without strobe");
      // R5: strobe on the load edge goes to the next load
      period(20'h0F0F0, 4, 20'h3C3C3, 20); expect_word(20'h0F0F0, "R5 load-edge strobe excluded");
      period('0, 0, '0, 0);         expect_word(20'h3C3C3, "R5 load-edge strobe next word");
      // R7: strobes at the start and end of the drain leave the word in flight intact
      period(20'h9E371, 10, '0, 0); expect_word(20'h9E371, "R7 word in flight undisturbed");
      period(20'h6D2B4, 1, 20'h6D2B5, 19); expect_word(20'h6D2B5, "R7 strobes during drain");
      // R3: random words back to back
      for (int i = 0; i < 12; i++) begin
         logic [W-1:0] w;
         int at;
         w  = W'($urandom());
         at = 1 + int'($urandom() % (W - 1));
         period(w, at, '0, 0);
         expect_word(w, "R3 back-to-back random");
      end
      period('0, 0, '0, 0);
      period('0, 0, '0, 0);
      chk(exp_q.size() == 0, "R3 all words delivered", 32'(exp_q.size()), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule